// File: doc/BRIEF.md
# Second-Level Cache Allocation Policy Filter

This block sits between the first-level instruction and data caches and the second-level cache controller. For each request it decides what the second-level cache may do with it: look it up, allocate a new line, update line data, send the request to the system bus, or pass it around the cache entirely. It also gives the state to record for any line it writes. The decision uses the request source, the access kind, the hit result from the tag lookup, and five static control bits: enable, data-only, instruction-only, write-through and test support. The tag and data arrays are outside this block.

The two restriction modes act only on misses. Data-only stops new instruction lines from being allocated. Instruction-only stops new data lines from being allocated. Hits from either source are still served. With both modes set, the cache is locked: no miss allocates, but write hits still update lines. Write-through sends every cache write to the bus as well and records lines as exclusive. Test support turns data-cache pushes and zero-line operations into cache-only writes, so software can fill the cache with chosen contents.

The decision is registered. It appears on the outputs one cycle after the request and stays only while requests keep arriving.

Top module: `alloc_policy_filter`

## Requirements
- R1: With `cfg_en` low, every request gives bypass=1 and forward=1. Lookup, allocate, update, invalidate and modified are all 0.
- R2: With the cache enabled, every valid request gives lookup=1. A read hit (kind 00) gives no bypass and no forward. A read miss allocates and forwards, with modified=0 (exclusive).
- R3: With data-only set, an instruction request (src=1) that hits is served like a normal hit. An instruction miss gives bypass=1 and forward=1 and never allocates.
- R4: With instruction-only set, a data request (src=0) that hits is served, and a store hit (kind 01) updates the line. A data miss gives bypass=1 and forward=1 and never allocates.
- R5: With both data-only and instruction-only set, no miss from either source allocates, and a store hit still gives update=1.
- R6: In write-back mode (`cfg_wthru` low), a store hit gives update=1, modified=1 and forward=0. A store miss also allocates, with modified=1 and forward=0.
- R7: With `cfg_wthru` set, every store that updates the cache also gives forward=1, and the line is recorded with modified=0 (exclusive).
- R8: With `cfg_test` set, a push (kind 10) updates the cache (allocating on a miss) with forward=0. The line state follows R6/R7.
- R9: A zero-line request (kind 11) updates the cache, allocating on a miss, and gives forward=1 only when `cfg_test` is clear. With `cfg_test` set, a store miss gives forward=0 even in write-through mode.
- R10: With `cfg_test` clear, a push that hits gives forward=1, invalidate=1 and update=0. A push that misses gives bypass=1 and forward=1 with no allocate.
- R11: Outputs reflect the request sampled at the previous rising clock edge. In a cycle after one with no valid request, all outputs are 0. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_src | input | 1 | Request source: 0 data cache, 1 instruction cache |
| req_kind | input | 2 | 00 read, 01 store, 10 push (castout/flush), 11 zero-line |
| req_hit | input | 1 | Tag lookup reports a hit |
| cfg_en | input | 1 | Second-level cache enabled |
| cfg_data_only | input | 1 | Block allocation of instruction misses |
| cfg_inst_only | input | 1 | Block allocation of data misses |
| cfg_wthru | input | 1 | Write-through mode |
| cfg_test | input | 1 | Test-support mode |
| out_lookup | output | 1 | Perform a tag/data lookup |
| out_alloc | output | 1 | Allocate a new line |
| out_update | output | 1 | Write line data |
| out_fwd | output | 1 | Send the request to the system bus |
| out_bypass | output | 1 | Request passes around the cache |
| out_inval | output | 1 | Invalidate the hit line |
| out_mod | output | 1 | Line state to record: 1 modified, 0 exclusive |

## Verification
A wrong mode gate shows up as a blocked miss that still allocates, or a served hit that bypasses. A wrong kind decode shows up as a forward bit or line state that does not match the write mode. Either error appears on the outputs at the first clock edge after the faulty request, because this block keeps no state beyond its one output register. The directed tests therefore check each combination in the cycle right after the request, and they check the all-zero outputs in the cycle after valid drops.

// File: rtl/alloc_policy_pkg.sv
// Package: shared encodings and the decision record used by the policy filter.
// Assumes request kind and source encodings fixed by the requirements.
package alloc_policy_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_READ  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_PUSH  = 2'b10,
        KIND_ZERO  = 2'b11
    } req_kind_e;

    localparam logic SRC_DATA = 1'b0;
    localparam logic SRC_INST = 1'b1;

    typedef struct packed {
        logic lookup;
        logic alloc;
        logic update;
        logic fwd;
        logic bypass;
        logic inval;
        logic modif;
    } decision_t;

    localparam int DEC_W = $bits(decision_t);

endpackage

// File: rtl/alloc_kind_decode.sv
// Module: per-kind action decode for a request already cleared to use the cache.
// Assumes the cache is enabled and the miss is not blocked by a restriction
// mode; the caller handles those cases. Purely combinational.
module alloc_kind_decode
    import alloc_policy_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              hit,
    input  logic              wthru,
    input  logic              test,
    output decision_t         act
);

    // Select the action for each access kind.
    always_comb begin
        act        = '0;
        act.lookup = 1'b1;
        unique case (req_kind_e'(kind))
            KIND_READ: begin
                act.alloc = !hit;
                act.fwd   = !hit;
            end
            KIND_STORE: begin
                act.alloc  = !hit;
                act.update = 1'b1;
                act.fwd    = wthru && !(test && !hit);
                act.modif  = !wthru;
            end
            KIND_PUSH: begin
                if (test) begin
                    act.alloc  = !hit;
                    act.update = 1'b1;
                    act.modif  = !wthru;
                end else begin
                    act.fwd    = 1'b1;
                    act.inval  = hit;
                    act.bypass = !hit;
                end
            end
            KIND_ZERO: begin
                act.alloc  = !hit;
                act.update = 1'b1;
                act.fwd    = !test;
                act.modif  = !wthru;
            end
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/alloc_mode_gate.sv
// Module: applies enable and the restriction modes ahead of the kind decode.
// Assumes the restriction modes act on misses only; hits pass to the decode.
// Purely combinational.
module alloc_mode_gate
    import alloc_policy_pkg::*;
(
    input  logic      en,
    input  logic      src,
    input  logic      hit,
    input  logic      data_only,
    input  logic      inst_only,
    input  decision_t kind_act,
    output decision_t gated
);

    logic miss_blocked;

    // Detect a miss whose source may not allocate under the current mode.
    always_comb begin
        miss_blocked = !hit && ((src == SRC_INST && data_only) ||
                                (src == SRC_DATA && inst_only));
    end

    // Choose between full bypass, blocked-miss bypass and the decoded action.
    always_comb begin
        gated = '0;
        if (!en) begin
            gated.fwd    = 1'b1;
            gated.bypass = 1'b1;
        end else if (miss_blocked) begin
            gated.lookup = 1'b1;
            gated.fwd    = 1'b1;
            gated.bypass = 1'b1;
        end else begin
            gated = kind_act;
        end
    end

endmodule

// File: rtl/alloc_out_stage.sv
// Module: output register holding the decision for one cycle after a request.
// Assumes a decision is meaningful only when the request was valid; otherwise
// the register loads zero.
module alloc_out_stage
    import alloc_policy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vld,
    input  decision_t nxt,
    output decision_t cur
);

    // Register the decision, or clear it when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (vld) begin
            cur <= nxt;
        end else begin
            cur <= '0;
        end
    end

endmodule

// File: rtl/alloc_policy_filter.sv
// Module: top of the second-level cache allocation policy filter.
// Decides lookup, allocate, update, forward, bypass, invalidate and the line
// state for each request, and registers the result for one cycle.
// Assumes the control bits are steady while requests are in flight.
module alloc_policy_filter
    import alloc_policy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_hit,
    input  logic              cfg_en,
    input  logic              cfg_data_only,
    input  logic              cfg_inst_only,
    input  logic              cfg_wthru,
    input  logic              cfg_test,
    output logic              out_lookup,
    output logic              out_alloc,
    output logic              out_update,
    output logic              out_fwd,
    output logic              out_bypass,
    output logic              out_inval,
    output logic              out_mod
);

    decision_t kind_act;
    decision_t gated;
    decision_t held;

    alloc_kind_decode u_kind (
        .kind  (req_kind),
        .hit   (req_hit),
        .wthru (cfg_wthru),
        .test  (cfg_test),
        .act   (kind_act)
    );

    alloc_mode_gate u_gate (
        .en        (cfg_en),
        .src       (req_src),
        .hit       (req_hit),
        .data_only (cfg_data_only),
        .inst_only (cfg_inst_only),
        .kind_act  (kind_act),
        .gated     (gated)
    );

    alloc_out_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (req_valid),
        .nxt   (gated),
        .cur   (held)
    );

    // Drive the ports from the held decision.
    always_comb begin
        out_lookup = held.lookup;
        out_alloc  = held.alloc;
        out_update = held.update;
        out_fwd    = held.fwd;
        out_bypass = held.bypass;
        out_inval  = held.inval;
        out_mod    = held.modif;
    end

    assert_disabled_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && !$past(cfg_en)) |->
            (out_bypass && !out_lookup && !out_alloc && !out_update));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid)) |->
            ($countones({out_lookup, out_alloc, out_update, out_fwd,
                         out_bypass, out_inval, out_mod}) == 0));

    assert_lock_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(cfg_data_only) &&
         $past(cfg_inst_only) && !$past(req_hit)) |-> !out_alloc);

    assert_store_hit_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(cfg_en) && $past(req_hit) &&
         $past(req_kind) == KIND_STORE) |-> out_update);

    assert_wthru_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wthru) && (out_update || out_alloc)) |-> !out_mod);

    assert_alloc_consistent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_alloc |-> (out_lookup && !out_bypass && !out_inval));

endmodule

// File: tb/sim_alloc_policy_filter.sv
`timescale 1ns/1ps
module sim_alloc_policy_filter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_src = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic req_hit = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_data_only = 1'b0;
    logic cfg_inst_only = 1'b0;
    logic cfg_wthru = 1'b0;
    logic cfg_test = 1'b0;
    logic out_lookup, out_alloc, out_update, out_fwd, out_bypass, out_inval, out_mod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alloc_policy_filter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_kind(req_kind), .req_hit(req_hit), .cfg_en(cfg_en),
        .cfg_data_only(cfg_data_only), .cfg_inst_only(cfg_inst_only),
        .cfg_wthru(cfg_wthru), .cfg_test(cfg_test),
        .out_lookup(out_lookup), .out_alloc(out_alloc), .out_update(out_update),
        .out_fwd(out_fwd), .out_bypass(out_bypass), .out_inval(out_inval),
        .out_mod(out_mod)
    );

    // Outputs packed as {lookup, alloc, update, fwd, bypass, inval, mod}.
    function automatic logic [6:0] outs();
        return {out_lookup, out_alloc, out_update, out_fwd, out_bypass, out_inval, out_mod};
    endfunction

    task automatic check(input logic [6:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, outs(), exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic dso, input logic iso,
                           input logic wt, input logic ts);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_en = en; cfg_data_only = dso; cfg_inst_only = iso;
        cfg_wthru = wt; cfg_test = ts;
    endtask

    // Present one request at a falling edge; check after the next rising edge.
    task automatic req(input logic src, input logic [1:0] kind, input logic hit,
                       input logic [6:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_kind = kind; req_hit = hit;
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic t_reset();
        check(7'b0, "R11 reset");
    endtask

    task automatic t_disabled();
        set_cfg(0, 0, 0, 0, 0);
        req(0, 2'b00, 1, 7'b0001100, "R1 disabled read");
        req(1, 2'b01, 0, 7'b0001100, "R1 disabled store");
    endtask

    task automatic t_basic();
        set_cfg(1, 0, 0, 0, 0);
        req(0, 2'b00, 1, 7'b1000000, "R2 read hit");
        req(1, 2'b00, 0, 7'b1101000, "R2 read miss");
    endtask

    task automatic t_data_only();
        set_cfg(1, 1, 0, 0, 0);
        req(1, 2'b00, 1, 7'b1000000, "R3 instr hit");
        req(1, 2'b00, 0, 7'b1001100, "R3 instr miss");
        req(0, 2'b00, 0, 7'b1101000, "R3 data miss allocates");
    endtask

    task automatic t_inst_only();
        set_cfg(1, 0, 1, 0, 0);
        req(0, 2'b01, 1, 7'b1010001, "R4 data store hit");
        req(0, 2'b01, 0, 7'b1001100, "R4 data store miss");
        req(1, 2'b00, 0, 7'b1101000, "R4 instr miss allocates");
    endtask

    task automatic t_locked();
        set_cfg(1, 1, 1, 0, 0);
        req(0, 2'b01, 1, 7'b1010001, "R5 locked store hit");
        req(1, 2'b00, 0, 7'b1001100, "R5 locked instr miss");
        req(0, 2'b00, 0, 7'b1001100, "R5 locked data miss");
    endtask

    task automatic t_write_back();
        set_cfg(1, 0, 0, 0, 0);
        req(0, 2'b01, 1, 7'b1010001, "R6 wb store hit");
        req(0, 2'b01, 0, 7'b1110001, "R6 wb store miss");
    endtask

    task automatic t_write_through();
        set_cfg(1, 0, 0, 1, 0);
        req(0, 2'b01, 1, 7'b1011000, "R7 wt store hit");
        req(0, 2'b01, 0, 7'b1111000, "R7 wt store miss");
    endtask

    task automatic t_test_mode();
        set_cfg(1, 0, 0, 0, 1);
        req(0, 2'b10, 0, 7'b1110001, "R8 test push miss");
        req(0, 2'b11, 0, 7'b1110001, "R9 test zero miss");
        set_cfg(1, 0, 0, 1, 1);
        req(0, 2'b10, 1, 7'b1010000, "R8 test push hit wt");
        req(0, 2'b01, 0, 7'b1110000, "R9 test wt store miss");
        set_cfg(1, 0, 0, 0, 0);
        req(0, 2'b11, 1, 7'b1011001, "R9 zero hit broadcast");
    endtask

    task automatic t_push_normal();
        set_cfg(1, 0, 0, 0, 0);
        req(0, 2'b10, 1, 7'b1001010, "R10 push hit");
        req(0, 2'b10, 0, 7'b1001100, "R10 push miss");
    endtask

    task automatic t_idle();
        set_cfg(1, 0, 0, 0, 0);
        req(0, 2'b00, 0, 7'b1101000, "R11 valid request");
        req_valid = 1'b0;
        @(negedge clk);
        check(7'b0, "R11 idle after request");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_disabled();
        t_basic();
        t_data_only();
        t_inst_only();
        t_locked();
        t_write_back();
        t_write_through();
        t_test_mode();
        t_push_normal();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule